// File: doc/BRIEF.md
# Ternary Lookup Table with Selectable Result Format

This block holds a small table of ternary patterns and answers the question "which stored patterns agree with this key?" in one clock cycle. Every entry keeps a data word, a per-bit care mask and a live flag. Entries are loaded through an address/data write port, in the same way as a RAM. A search key is compared against all live entries at the same moment. The answer is registered and appears on the cycle after the key is presented.

Each stored bit takes one of four states. It can be an exact 0, an exact 1, a wildcard that agrees with any key bit, or, when the enhanced parameter is set, a blocker that agrees with no key bit. A wildcard lets one entry cover a whole aligned range, such as every value that shares a given prefix. A blocker lets software disable part of an entry without erasing it.

The result format is chosen at build time with a parameter:
- an encoded address plus a hit flag;
- a one-hot vector that marks only the winning entry;
- a multi-hit vector that marks every agreeing entry.

The table can be preloaded from constant parameters at reset and rewritten at any time while running.

The block has no state machine. The only sequential elements are the entry store, which is written on an enabled write, and the result register, which is loaded on each search.

Top module: `tcam`

## Requirements
- R1: A search sampled with `srch_en` high at a rising edge produces `res_valid` high on the following cycle, with the result computed from the key and table contents as they stood before that edge.
- R2: A stored bit with care=1 agrees only with an equal key bit. A stored bit with care=0 and value=0 is a wildcard and agrees with any key bit.
- R3: A stored bit with care=0 and value=1 is a blocker when ENHANCED=1 and never agrees. When ENHANCED=0 the same bit acts as a wildcard.
- R4: An entry whose live flag is 0 never reports a hit. A write with `wr_live`=0 removes the entry from searches.
- R5: In encoded format, `res_hit` is 1 if any entry agrees, `res_addr` is the lowest agreeing index, and `res_vec` is 0. With no agreeing entry, `res_hit` and `res_addr` are 0.
- R6: In one-hot format, only the bit of the lowest agreeing entry is set in `res_vec`, entry i sits at bit DEPTH-1-i, and `res_addr` is 0.
- R7: In multi-hit format, `res_vec` has the bit of every agreeing entry set, with entry i at bit DEPTH-1-i (a lone hit on entry 2 of 8 gives 00100000). `res_hit` is 1 exactly when `res_vec` is nonzero.
- R8: While reset is active, each entry i is loaded from INIT_DATA, INIT_CARE and INIT_LIVE (slice i), and all result outputs are cleared.
- R9: A write overwrites the addressed entry for all later searches. A search in the same cycle as a write to the same entry sees the old contents.
- R10: In a cycle that samples no search, `res_valid` falls on the next cycle while `res_hit`, `res_addr` and `res_vec` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Entry index to write |
| wr_data | input | WIDTH | Stored value bits |
| wr_care | input | WIDTH | Care mask (1 = compare exactly) |
| wr_live | input | 1 | Live flag written with the entry |
| srch_en | input | 1 | Search strobe |
| srch_key | input | WIDTH | Key to look up |
| res_valid | output | 1 | Result present this cycle |
| res_hit | output | 1 | At least one entry agreed |
| res_addr | output | AW | Lowest agreeing index (encoded format) |
| res_vec | output | DEPTH | Hit vector, entry 0 at the MSB (unencoded formats) |

## Verification
The bench runs four instances from the same stimulus: encoded, one-hot and multi-hit, all with ENHANCED=1, plus encoded with ENHANCED=0.

It aims at the following corner cases, each with the failure a faulty design would show:
- **Several entries agreeing at once.** A design that picks the highest index, or reverses the vector order, reports entry 3 instead of 0 or a mirrored vector.
- **Blocker bits.** A design that treats them as wildcards hits entry 5 on key 00 in the enhanced build. A design that blocks in the standard build misses it there.
- **Write and search on the same entry in one cycle.** A design that forwards the new data loses the old hit.
- **Entry removal.** A design that ignores the live flag keeps reporting the wildcard entry.
- **Idle cycle.** A design that clears or changes the result on an idle cycle fails the hold check.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    typedef enum logic [1:0] {
        FMT_ENCODED = 2'd0,
        FMT_ONEHOT  = 2'd1,
        FMT_MULTI   = 2'd2
    } fmt_e;

    function automatic int addr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
    parameter int                      WIDTH     = 8,
    parameter int                      DEPTH     = 8,
    parameter int                      AW        = 3,
    parameter logic [DEPTH*WIDTH-1:0]  INIT_DATA = '0,
    parameter logic [DEPTH*WIDTH-1:0]  INIT_CARE = '0,
    parameter logic [DEPTH-1:0]        INIT_LIVE = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [WIDTH-1:0]              wr_data,
    input  logic [WIDTH-1:0]              wr_care,
    input  logic                          wr_live,
    output logic [DEPTH-1:0][WIDTH-1:0]   ent_val,
    output logic [DEPTH-1:0][WIDTH-1:0]   ent_care,
    output logic [DEPTH-1:0]              ent_live
);

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_addr == AW'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_val[e]  <= INIT_DATA[e*WIDTH +: WIDTH];
                ent_care[e] <= INIT_CARE[e*WIDTH +: WIDTH];
                ent_live[e] <= INIT_LIVE[e];
            end else if (sel) begin
                ent_val[e]  <= wr_data;
                ent_care[e] <= wr_care;
                ent_live[e] <= wr_live;
            end
        end
    end

endmodule

// File: rtl/tcam_match.sv
module tcam_match #(
    parameter int WIDTH    = 8,
    parameter int DEPTH    = 8,
    parameter bit ENHANCED = 1'b1
) (
    input  logic [WIDTH-1:0]              key,
    input  logic [DEPTH-1:0][WIDTH-1:0]   ent_val,
    input  logic [DEPTH-1:0][WIDTH-1:0]   ent_care,
    input  logic [DEPTH-1:0]              ent_live,
    output logic [DEPTH-1:0]              hit
);

    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
        logic [WIDTH-1:0] exact_ok;
        logic [WIDTH-1:0] loose_ok;
        logic [WIDTH-1:0] bit_ok;

        assign exact_ok = ent_care[e] & ~(key ^ ent_val[e]);

        if (ENHANCED) begin : g_enh
            // care=0,value=1 is a blocker
            assign loose_ok = ~ent_care[e] & ~ent_val[e];
        end else begin : g_std
            // care=0 always a wildcard
            assign loose_ok = ~ent_care[e];
        end

        assign bit_ok = exact_ok | loose_ok;
        assign hit[e] = ent_live[e] & (&bit_ok);
    end

endmodule

// File: rtl/tcam_format.sv
module tcam_format
    import tcam_pkg::*;
#(
    parameter int   DEPTH = 8,
    parameter int   AW    = 3,
    parameter fmt_e FMT   = FMT_ENCODED
) (
    input  logic [DEPTH-1:0] hit,
    output logic             any_hit,
    output logic [AW-1:0]    addr,
    output logic [DEPTH-1:0] vec
);

    assign any_hit = |hit;

    if (FMT == FMT_ENCODED) begin : g_enc
        always_comb begin
            addr = '0;
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (hit[i]) addr = AW'(i);
            end
        end
        assign vec = '0;
    end else if (FMT == FMT_ONEHOT) begin : g_oh
        logic [DEPTH-1:0] lowest;
        assign lowest = hit & (~hit + DEPTH'(1));
        for (genvar i = 0; i < DEPTH; i++) begin : g_rev
            assign vec[DEPTH-1-i] = lowest[i];
        end
        assign addr = '0;
    end else begin : g_multi
        for (genvar i = 0; i < DEPTH; i++) begin : g_rev
            assign vec[DEPTH-1-i] = hit[i];
        end
        assign addr = '0;
    end

endmodule

// File: rtl/tcam.sv
module tcam
    import tcam_pkg::*;
#(
    parameter int                      WIDTH     = 8,
    parameter int                      DEPTH     = 8,
    parameter bit                      ENHANCED  = 1'b1,
    parameter fmt_e                    FMT       = FMT_ENCODED,
    parameter logic [DEPTH*WIDTH-1:0]  INIT_DATA = '0,
    parameter logic [DEPTH*WIDTH-1:0]  INIT_CARE = '0,
    parameter logic [DEPTH-1:0]        INIT_LIVE = '0,
    localparam int                     AW        = addr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] wr_care,
    input  logic             wr_live,
    input  logic             srch_en,
    input  logic [WIDTH-1:0] srch_key,
    output logic             res_valid,
    output logic             res_hit,
    output logic [AW-1:0]    res_addr,
    output logic [DEPTH-1:0] res_vec
);

    logic [DEPTH-1:0][WIDTH-1:0] ent_val;
    logic [DEPTH-1:0][WIDTH-1:0] ent_care;
    logic [DEPTH-1:0]            ent_live;
    logic [DEPTH-1:0]            hit;
    logic                        nx_hit;
    logic [AW-1:0]               nx_addr;
    logic [DEPTH-1:0]            nx_vec;

    tcam_store #(
        .WIDTH     (WIDTH),
        .DEPTH     (DEPTH),
        .AW        (AW),
        .INIT_DATA (INIT_DATA),
        .INIT_CARE (INIT_CARE),
        .INIT_LIVE (INIT_LIVE)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_care  (wr_care),
        .wr_live  (wr_live),
        .ent_val  (ent_val),
        .ent_care (ent_care),
        .ent_live (ent_live)
    );

    tcam_match #(
        .WIDTH    (WIDTH),
        .DEPTH    (DEPTH),
        .ENHANCED (ENHANCED)
    ) u_match (
        .key      (srch_key),
        .ent_val  (ent_val),
        .ent_care (ent_care),
        .ent_live (ent_live),
        .hit      (hit)
    );

    tcam_format #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .FMT   (FMT)
    ) u_fmt (
        .hit     (hit),
        .any_hit (nx_hit),
        .addr    (nx_addr),
        .vec     (nx_vec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_addr  <= '0;
            res_vec   <= '0;
        end else begin
            res_valid <= srch_en;
            if (srch_en) begin
                res_hit  <= nx_hit;
                res_addr <= nx_addr;
                res_vec  <= nx_vec;
            end
        end
    end

endmodule

// File: rtl/tcam_chk.sv
module tcam_chk
    import tcam_pkg::*;
#(
    parameter int   DEPTH = 8,
    parameter int   AW    = 3,
    parameter fmt_e FMT   = FMT_ENCODED
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srch_en,
    input logic             res_valid,
    input logic             res_hit,
    input logic [AW-1:0]    res_addr,
    input logic [DEPTH-1:0] res_vec
);

    AST_SEARCH_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> res_valid); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> (!res_valid && $stable(res_addr) && $stable(res_vec) && $stable(res_hit))); // R10

    AST_ENC_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (FMT == FMT_ENCODED && res_valid && !res_hit) |-> (res_addr == '0)); // R5

    AST_ENC_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (FMT == FMT_ENCODED && res_valid) |-> (res_vec == '0)); // R5

    AST_ONEHOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (FMT == FMT_ONEHOT && res_valid) |-> ($onehot0(res_vec) && (res_hit == (res_vec != '0)))); // R6

    AST_MULTI_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (FMT == FMT_MULTI && res_valid) |-> (res_hit == (res_vec != '0))); // R7

endmodule

bind tcam tcam_chk #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .FMT   (FMT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .srch_en   (srch_en),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_addr  (res_addr),
    .res_vec   (res_vec)
);

// File: tb/tcam_tb.sv
`timescale 1ns/1ps
module tcam_tb;
    import tcam_pkg::*;

    localparam int W = 8;
    localparam int D = 8;
    localparam int A = 3;
    localparam logic [D*W-1:0] P_DATA = 64'h00000000_000000A5;
    localparam logic [D*W-1:0] P_CARE = 64'h00000000_000000FF;
    localparam logic [D-1:0]   P_LIVE = 8'h01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [A-1:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] wr_care = '0;
    logic wr_live = 1'b0;
    logic srch_en = 1'b0;
    logic [W-1:0] srch_key = '0;

    logic v_e, h_e, v_o, h_o, v_m, h_m, v_s, h_s;
    logic [A-1:0] a_e, a_o, a_m, a_s;
    logic [D-1:0] q_e, q_o, q_m, q_s;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tcam #(.WIDTH(W), .DEPTH(D), .ENHANCED(1'b1), .FMT(FMT_ENCODED),
           .INIT_DATA(P_DATA), .INIT_CARE(P_CARE), .INIT_LIVE(P_LIVE)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_care(wr_care), .wr_live(wr_live), .srch_en(srch_en), .srch_key(srch_key),
        .res_valid(v_e), .res_hit(h_e), .res_addr(a_e), .res_vec(q_e));

    tcam #(.WIDTH(W), .DEPTH(D), .ENHANCED(1'b1), .FMT(FMT_ONEHOT),
           .INIT_DATA(P_DATA), .INIT_CARE(P_CARE), .INIT_LIVE(P_LIVE)) u_dut_oh (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_care(wr_care), .wr_live(wr_live), .srch_en(srch_en), .srch_key(srch_key),
        .res_valid(v_o), .res_hit(h_o), .res_addr(a_o), .res_vec(q_o));

    tcam #(.WIDTH(W), .DEPTH(D), .ENHANCED(1'b1), .FMT(FMT_MULTI),
           .INIT_DATA(P_DATA), .INIT_CARE(P_CARE), .INIT_LIVE(P_LIVE)) u_dut_mm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_care(wr_care), .wr_live(wr_live), .srch_en(srch_en), .srch_key(srch_key),
        .res_valid(v_m), .res_hit(h_m), .res_addr(a_m), .res_vec(q_m));

    tcam #(.WIDTH(W), .DEPTH(D), .ENHANCED(1'b0), .FMT(FMT_ENCODED),
           .INIT_DATA(P_DATA), .INIT_CARE(P_CARE), .INIT_LIVE(P_LIVE)) u_dut_std (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_care(wr_care), .wr_live(wr_live), .srch_en(srch_en), .srch_key(srch_key),
        .res_valid(v_s), .res_hit(h_s), .res_addr(a_s), .res_vec(q_s));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [A-1:0] ad, input logic [W-1:0] dt,
                            input logic [W-1:0] cr, input logic lv);
        wr_en = 1'b1; wr_addr = ad; wr_data = dt; wr_care = cr; wr_live = lv;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_search(input logic [W-1:0] k);
        srch_en = 1'b1; srch_key = k;
        @(negedge clk);
        srch_en = 1'b0;
    endtask

    task automatic t_reset_preload();
        check("R8 reset valid", 32'(v_e), 0);
        check("R8 reset hit", 32'(h_m), 0);
        check("R8 reset vec", 32'(q_m), 0);
        do_search(8'hA5);
        check("R1 valid after search", 32'(v_e), 1);
        check("R8 preload hit", 32'(h_e), 1);
        check("R8 preload addr", 32'(a_e), 0);
        check("R7 preload vec", 32'(q_m), 32'h80);
        do_search(8'hA4);
        check("R5 miss hit", 32'(h_e), 0);
        check("R5 miss addr", 32'(a_e), 0);
        check("R5 miss vec", 32'(q_e), 0);
    endtask

    task automatic t_wildcard();
        do_write(3'd3, 8'hA0, 8'hF0, 1'b1);
        do_search(8'hAB);
        check("R2 wildcard hit", 32'(h_e), 1);
        check("R2 wildcard addr", 32'(a_e), 3);
        check("R7 entry3 vec", 32'(q_m), 32'h10);
        do_search(8'hA5);
        check("R5 lowest index", 32'(a_e), 0);
        check("R6 onehot lowest", 32'(q_o), 32'h80);
        check("R6 onehot addr", 32'(a_o), 0);
        check("R7 multi both", 32'(q_m), 32'h90);
        do_search(8'hB0);
        check("R2 exact mismatch", 32'(h_e), 0);
    endtask

    task automatic t_blocker();
        do_write(3'd5, 8'h01, 8'hFE, 1'b1);
        do_search(8'h00);
        check("R3 blocker enh key00", 32'(h_e), 0);
        check("R3 std wildcard hit", 32'(h_s), 1);
        check("R3 std wildcard addr", 32'(a_s), 5);
        do_search(8'h01);
        check("R3 blocker enh key01", 32'(h_e), 0);
        check("R3 std key01 addr", 32'(a_s), 5);
    endtask

    task automatic t_multi();
        do_write(3'd2, 8'h00, 8'h00, 1'b1);
        do_search(8'h77);
        check("R7 lone entry2", 32'(q_m), 32'h20);
        check("R5 addr entry2", 32'(a_e), 2);
        check("R6 onehot entry2", 32'(q_o), 32'h20);
        do_search(8'hA5);
        check("R7 three hits", 32'(q_m), 32'hB0);
        check("R6 onehot of three", 32'(q_o), 32'h80);
        check("R5 lowest of three", 32'(a_e), 0);
    endtask

    task automatic t_remove();
        do_write(3'd2, 8'h00, 8'h00, 1'b0);
        do_search(8'h77);
        check("R4 removed miss", 32'(h_e), 0);
        check("R4 removed vec", 32'(q_m), 0);
    endtask

    task automatic t_same_cycle();
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'hC0; wr_care = 8'hFF; wr_live = 1'b1;
        srch_en = 1'b1; srch_key = 8'hAB;
        @(negedge clk);
        wr_en = 1'b0; srch_en = 1'b0;
        check("R9 old contents hit", 32'(h_e), 1);
        check("R9 old contents addr", 32'(a_e), 3);
        do_search(8'hAB);
        check("R9 overwritten miss", 32'(h_e), 0);
        do_search(8'hC0);
        check("R9 new contents addr", 32'(a_e), 3);
        check("R9 new contents hit", 32'(h_e), 1);
    endtask

    task automatic t_idle();
        @(negedge clk);
        check("R10 valid low", 32'(v_e), 0);
        check("R10 addr held", 32'(a_e), 3);
        check("R10 hit held", 32'(h_e), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_preload();
        t_wildcard();
        t_blocker();
        t_multi();
        t_remove();
        t_same_cycle();
        t_idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule